// File: doc/BRIEF.md
# Conversion Autosequencer Controller

This block steps a shared analog-to-digital converter through programmed lists of conversion slots for two sequencers. Each sequencer starts when a trigger arrives while it is idle. For each slot it requests one conversion from the external converter and waits for the done handshake. It then writes a result at the index of the slot it just converted. When its remaining-conversion count is exhausted it signals end-of-sequence.

The two sequencers can work independently, with eight slots each: sequencer 1 owns slots 0 to 7 and sequencer 2 owns slots 8 to 15. They can also be joined into a single sixteen-slot sequencer. A finished sequence stays on the slot where it stopped, so the next trigger continues into the following slots and wraps inside its own region. A trigger that arrives while a sequence is running is held as one pending request. A software reset per sequencer aborts the sequence at once and returns it to its start slot. Each sequencer has a sticky interrupt flag that is raised either on every end-of-sequence or on every second one.

Top module: `adc_autoseq`

## Requirements
- R1: After reset both sequencers are idle (`busy` = 00), `conv_req` is 0 and `irq` is 00. The first sequence of sequencer 1 uses slot 0 and the first sequence of sequencer 2 uses slot 8.
- R2: A trigger on an idle sequencer with max setting N performs exactly N+1 conversions. `conv_req` holds its value and `conv_slot` stays stable until `conv_done`. Each accepted done produces one `res_we` pulse with `res_idx` equal to the converted slot.
- R3: A sequence that ends without a reset leaves the pointer on the slot after the last one converted. The next sequence begins there. In dual mode the pointer wraps within the sequencer's own 8 slots, so 7 is followed by 0 and 15 is followed by 8.
- R4: A trigger that arrives during an active sequence is held as a single pending request. That request starts exactly one further sequence right after the current one ends. Any further triggers arriving while a request is pending are dropped.
- R5: `seq_rst[k]` aborts sequencer k: `busy[k]` is 0 on the next cycle, its pointer returns to its start slot, its pending request is discarded, and the conversion it has in flight is dropped.
- R6: With `cascade`=1, sequencer 1 spans slots 0 to 15 and uses all 4 bits of its max setting (N up to 15). Triggers to sequencer 2 are ignored and `busy[1]` stays 0.
- R7: In dual mode only the low 3 bits of a max setting are used, so a setting of 4'hA gives 3 conversions.
- R8: With `irq_mode[k]`=0, each end-of-sequence of sequencer k sets `irq[k]`. The flag stays set until an `irq_clr[k]` pulse, and a set in the same cycle as a clear wins.
- R9: With `irq_mode[k]`=1, `irq[k]` is set only on every second end-of-sequence. `seq_rst[k]` restarts that count, so the first end-of-sequence after a reset does not set the flag.
- R10: When both sequencers are waiting for the converter, sequencer 1 is granted first. A conversion that has been granted is never taken over by the other sequencer.
- R11: `eos[k]` pulses for one cycle together with the done of the last conversion, and `busy[k]` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cascade | input | 1 | 1 = single 16-slot sequencer, 0 = two 8-slot sequencers |
| trig | input | 2 | Start triggers; bit 0 for sequencer 1, bit 1 for sequencer 2 |
| seq_rst | input | 2 | Per-sequencer abort-and-rewind pulse |
| max_conv1 | input | 4 | Conversions minus one for sequencer 1 |
| max_conv2 | input | 4 | Conversions minus one for sequencer 2 |
| irq_mode | input | 2 | Per-sequencer interrupt mode: 0 every end, 1 every second end |
| irq_clr | input | 2 | Per-sequencer interrupt flag clear pulse |
| conv_req | output | 1 | Conversion request to the converter, held until done |
| conv_slot | output | 4 | Slot index being converted |
| conv_done | input | 1 | Converter done pulse |
| res_we | output | 1 | Result write strobe |
| res_idx | output | 4 | Result slot index |
| eos | output | 2 | End-of-sequence pulses |
| busy | output | 2 | Sequencer running |
| irq | output | 2 | Sticky interrupt flags |

## Verification
The assertions assume that `cascade` and the max settings are stable while a sequencer runs. They also assume that `conv_done` is a single-cycle pulse that only means something while `conv_req` is high. The bench changes configuration only between scenarios, after both sequencers have gone quiet. Its converter model raises done for one cycle a fixed number of cycles after the request rises, and it drops its count when the request is withdrawn by an abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {
    IRQ_EVERY = 1'b0,
    IRQ_ALT   = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cascade,
  input  logic              region_hi,
  input  logic              trig,
  input  logic              seq_rst,
  input  logic [SLOT_W-1:0] max_conv,
  input  logic              irq_mode,
  input  logic              irq_clr,
  input  logic              done,
  output logic              active,
  output logic [SLOT_W-1:0] ptr,
  output logic              eos,
  output logic              irq
);
  localparam logic [SLOT_W-1:0] HI_BASE = {1'b1, {(SLOT_W-1){1'b0}}};

  logic              act_q, act_n;
  logic              pend_q, pend_n;
  logic              tog_q, tog_n;
  logic              irq_q, irq_n;
  logic [SLOT_W-1:0] ptr_q, ptr_n;
  logic [SLOT_W-1:0] cnt_q, cnt_n;
  logic [SLOT_W-1:0] start_slot, eff_max, ptr_inc;
  logic              start, last_done, irq_fire;

  assign start_slot = region_hi ? HI_BASE : '0;
  assign eff_max    = cascade ? max_conv : {1'b0, max_conv[SLOT_W-2:0]};
  assign ptr_inc    = cascade ? ptr_q + 1'b1
                              : {ptr_q[SLOT_W-1], ptr_q[SLOT_W-2:0] + 1'b1};
  assign start      = !act_q && (trig || pend_q);
  assign last_done  = act_q && done && (cnt_q == '0) && !seq_rst;
  assign irq_fire   = last_done && ((irq_mode_e'(irq_mode) == IRQ_EVERY) || tog_q);

  always_comb begin
    act_n  = act_q;
    pend_n = pend_q;
    tog_n  = tog_q;
    ptr_n  = ptr_q;
    cnt_n  = cnt_q;
    if (seq_rst) begin
      act_n  = 1'b0;
      pend_n = 1'b0;
      tog_n  = 1'b0;
      ptr_n  = start_slot;
      cnt_n  = '0;
    end else begin
      if (start) begin
        act_n  = 1'b1;
        cnt_n  = eff_max;
        pend_n = 1'b0;
      end else if (act_q && trig) begin
        pend_n = 1'b1;
      end
      if (act_q && done) begin
        ptr_n = ptr_inc;
        if (cnt_q == '0) begin
          act_n = 1'b0;
          if (irq_mode_e'(irq_mode) == IRQ_ALT) tog_n = !tog_q;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
    irq_n = irq_q;
    if (irq_clr)  irq_n = 1'b0;
    if (irq_fire) irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      tog_q  <= 1'b0;
      irq_q  <= 1'b0;
      ptr_q  <= start_slot;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_n;
      pend_q <= pend_n;
      tog_q  <= tog_n;
      irq_q  <= irq_n;
      ptr_q  <= ptr_n;
      cnt_q  <= cnt_n;
    end
  end

  assign active = act_q;
  assign ptr    = ptr_q;
  assign eos    = last_done;
  assign irq    = irq_q;
endmodule

// File: rtl/adc_conv_arb.sv
module adc_conv_arb #(
  parameter int SLOT_W = 4,
  parameter int NSEQ   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSEQ-1:0]             req,
  input  logic [NSEQ-1:0]             abort,
  input  logic [NSEQ-1:0][SLOT_W-1:0] slot,
  input  logic                        conv_done,
  output logic [NSEQ-1:0]             done_o,
  output logic                        conv_req,
  output logic [SLOT_W-1:0]           conv_slot
);
  localparam int OWN_W = (NSEQ > 1) ? $clog2(NSEQ) : 1;

  logic             busy_q, busy_n;
  logic [OWN_W-1:0] own_q, own_n;
  logic [NSEQ-1:0]  eligible;

  assign eligible = req & ~abort;

  always_comb begin
    busy_n = busy_q;
    own_n  = own_q;
    if (busy_q) begin
      if (conv_done || abort[own_q]) busy_n = 1'b0;
    end else begin
      for (int k = NSEQ - 1; k >= 0; k--) begin
        if (eligible[k]) begin
          busy_n = 1'b1;
          own_n  = OWN_W'(k);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= '0;
    end else begin
      busy_q <= busy_n;
      own_q  <= own_n;
    end
  end

  for (genvar g = 0; g < NSEQ; g++) begin : g_done
    assign done_o[g] = conv_done && busy_q && (own_q == OWN_W'(g));
  end

  assign conv_req  = busy_q;
  assign conv_slot = slot[own_q];
endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq #(
  parameter int HALF_SLOTS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cascade,
  input  logic [1:0]                          trig,
  input  logic [1:0]                          seq_rst,
  input  logic [$clog2(HALF_SLOTS):0]         max_conv1,
  input  logic [$clog2(HALF_SLOTS):0]         max_conv2,
  input  logic [1:0]                          irq_mode,
  input  logic [1:0]                          irq_clr,
  output logic                                conv_req,
  output logic [$clog2(HALF_SLOTS):0]         conv_slot,
  input  logic                                conv_done,
  output logic                                res_we,
  output logic [$clog2(HALF_SLOTS):0]         res_idx,
  output logic [1:0]                          eos,
  output logic [1:0]                          busy,
  output logic [1:0]                          irq
);
  localparam int SLOT_W = $clog2(HALF_SLOTS) + 1;
  localparam int NSEQ   = 2;

  logic [1:0]                  rst_sync;
  logic                        rst_i;
  logic [NSEQ-1:0]             trig_eff, act, done_v;
  logic [NSEQ-1:0][SLOT_W-1:0] ptr_v, max_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign trig_eff = {trig[1] & ~cascade, trig[0]};
  assign max_v    = {max_conv2, max_conv1};

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    adc_seq_engine #(.SLOT_W(SLOT_W)) i_eng (
      .clk       (clk),
      .rst_n     (rst_i),
      .cascade   (cascade),
      .region_hi (g == 1),
      .trig      (trig_eff[g]),
      .seq_rst   (seq_rst[g]),
      .max_conv  (max_v[g]),
      .irq_mode  (irq_mode[g]),
      .irq_clr   (irq_clr[g]),
      .done      (done_v[g]),
      .active    (act[g]),
      .ptr       (ptr_v[g]),
      .eos       (eos[g]),
      .irq       (irq[g])
    );
  end

  adc_conv_arb #(.SLOT_W(SLOT_W), .NSEQ(NSEQ)) i_arb (
    .clk       (clk),
    .rst_n     (rst_i),
    .req       (act),
    .abort     (seq_rst),
    .slot      (ptr_v),
    .conv_done (conv_done),
    .done_o    (done_v),
    .conv_req  (conv_req),
    .conv_slot (conv_slot)
  );

  assign busy    = act;
  assign res_we  = |done_v;
  assign res_idx = conv_slot;
endmodule

// File: rtl/adc_autoseq_chk.sv
module adc_autoseq_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cascade,
  input logic [1:0]   trig,
  input logic [1:0]   seq_rst,
  input logic         conv_req,
  input logic [W-1:0] conv_slot,
  input logic         conv_done,
  input logic         res_we,
  input logic [1:0]   eos,
  input logic [1:0]   busy,
  input logic [1:0]   irq,
  input logic [1:0]   irq_clr
);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done && (seq_rst == 2'b00) |=> conv_req && $stable(conv_slot));
  a_r2_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> conv_req && conv_done);
  a_r5_rst_idle0: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst[0] |=> !busy[0]);
  a_r5_rst_idle1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst[1] |=> !busy[1]);
  a_r6_casc_seq2: assert property (@(posedge clk) disable iff (!rst_n)
    cascade && trig[1] && !busy[1] |=> !busy[1]);
  a_r8_irq_sticky0: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] && !irq_clr[0] |=> irq[0]);
  a_r8_irq_sticky1: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] && !irq_clr[1] |=> irq[1]);
  a_r11_eos_idle0: assert property (@(posedge clk) disable iff (!rst_n)
    eos[0] |=> !busy[0]);
  a_r11_eos_idle1: assert property (@(posedge clk) disable iff (!rst_n)
    eos[1] |=> !busy[1]);
  a_r11_eos_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (eos != 2'b00) |-> res_we);
endmodule

bind adc_autoseq adc_autoseq_chk #(.W(SLOT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cascade   (cascade),
  .trig      (trig),
  .seq_rst   (seq_rst),
  .conv_req  (conv_req),
  .conv_slot (conv_slot),
  .conv_done (conv_done),
  .res_we    (res_we),
  .eos       (eos),
  .busy      (busy),
  .irq       (irq),
  .irq_clr   (irq_clr)
);

// File: tb/test_adc_autoseq.sv
`timescale 1ns/1ps
module test_adc_autoseq;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cascade;
  logic [1:0] trig, seq_rst, irq_mode, irq_clr;
  logic [3:0] max_conv1, max_conv2;
  logic       conv_req, conv_done, res_we;
  logic [3:0] conv_slot, res_idx;
  logic [1:0] eos, busy, irq;

  int checks = 0;
  int errors = 0;
  int lg[0:63];
  int nlog = 0;
  int neos0 = 0;
  int neos1 = 0;
  int busy1_seen = 0;
  int cyc = 0;
  int rc = 0;

  always #2 clk = ~clk;

  adc_autoseq i_adc_autoseq (
    .clk(clk), .rst_n(rst_n), .cascade(cascade), .trig(trig), .seq_rst(seq_rst),
    .max_conv1(max_conv1), .max_conv2(max_conv2), .irq_mode(irq_mode), .irq_clr(irq_clr),
    .conv_req(conv_req), .conv_slot(conv_slot), .conv_done(conv_done),
    .res_we(res_we), .res_idx(res_idx), .eos(eos), .busy(busy), .irq(irq)
  );

  // converter model: done pulse a fixed time after request, restarts on withdrawal
  always @(posedge clk) begin
    if (!conv_req) begin
      rc <= 0;
      conv_done <= 1'b0;
    end else if (conv_done) begin
      rc <= 0;
      conv_done <= 1'b0;
    end else if (rc == LAT) begin
      conv_done <= 1'b1;
    end else begin
      rc <= rc + 1;
    end
  end

  always @(negedge clk) begin
    if (res_we && nlog < 64) begin
      lg[nlog] = int'(res_idx);
      nlog++;
    end
    if (eos[0]) neos0++;
    if (eos[1]) neos1++;
    if (busy[1]) busy1_seen = 1;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nlog = 0; neos0 = 0; neos1 = 0; busy1_seen = 0;
  endtask

  task automatic pulse_trig(logic [1:0] m);
    @(negedge clk); trig = m;
    @(negedge clk); trig = 2'b00;
  endtask

  task automatic pulse_rst(logic [1:0] m);
    @(negedge clk); seq_rst = m;
    @(negedge clk); seq_rst = 2'b00;
  endtask

  task automatic pulse_clr(logic [1:0] m);
    @(negedge clk); irq_clr = m;
    @(negedge clk); irq_clr = 2'b00;
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int i = 0; i < 3000 && q < 4; i++) begin
      @(negedge clk);
      if (busy == 2'b00 && !conv_req) q++;
      else q = 0;
    end
  endtask

  task automatic fresh(logic casc, logic [1:0] mode);
    wait_quiet();
    @(negedge clk); cascade = casc; irq_mode = mode;
    pulse_rst(2'b11);
    pulse_clr(2'b11);
    clear_log();
  endtask

  task automatic t_reset();
    check("R1 busy after reset", int'(busy), 0);
    check("R1 conv_req after reset", int'(conv_req), 0);
    check("R1 irq after reset", int'(irq), 0);
  endtask

  task automatic t_basic();
    fresh(1'b0, 2'b00);
    max_conv1 = 4'd1;
    pulse_trig(2'b01);
    wait_quiet();
    check("R2 conversions for N=1", nlog, 2);
    check("R1 first slot seq1", lg[0], 0);
    check("R2 second slot", lg[1], 1);
    check("R11 one eos", neos0, 1);
    check("R8 irq set at eos", int'(irq[0]), 1);
    pulse_clr(2'b01);
    check("R8 irq cleared", int'(irq[0]), 0);
  endtask

  task automatic t_resume();
    clear_log();
    max_conv1 = 4'd1;
    pulse_trig(2'b01);
    wait_quiet();
    check("R3 resume slot", lg[0], 2);
    max_conv1 = 4'd3;
    pulse_trig(2'b01);
    wait_quiet();
    max_conv1 = 4'd1;
    pulse_trig(2'b01);
    wait_quiet();
    check("R3 writes", nlog, 8);
    check("R3 last of region", lg[5], 7);
    check("R3 wrap to 0", lg[6], 0);
  endtask

  task automatic t_pend();
    fresh(1'b0, 2'b00);
    max_conv1 = 4'd1;
    pulse_trig(2'b01);
    pulse_trig(2'b01);
    pulse_trig(2'b01);
    wait_quiet();
    check("R4 one extra sequence writes", nlog, 4);
    check("R4 eos count", neos0, 2);
    check("R4 continues slot", lg[3], 3);
  endtask

  task automatic t_abort();
    fresh(1'b0, 2'b00);
    max_conv1 = 4'd7;
    pulse_trig(2'b01);
    pulse_trig(2'b01);
    for (int i = 0; i < 500 && nlog < 2; i++) @(negedge clk);
    seq_rst = 2'b01;
    @(negedge clk); seq_rst = 2'b00;
    check("R5 busy low after reset", int'(busy[0]), 0);
    wait_quiet();
    check("R5 pending dropped", nlog, 2);
    check("R5 no eos", neos0, 0);
    max_conv1 = 4'd0;
    pulse_trig(2'b01);
    wait_quiet();
    check("R5 rewound to start", lg[2], 0);
  endtask

  task automatic t_seq2();
    fresh(1'b0, 2'b00);
    max_conv2 = 4'd7;
    pulse_trig(2'b10);
    wait_quiet();
    pulse_trig(2'b10);
    wait_quiet();
    check("R1 seq2 start slot", lg[0], 8);
    check("R3 seq2 last", lg[7], 15);
    check("R3 seq2 wrap", lg[8], 8);
    check("R8 seq2 irq", int'(irq[1]), 1);
  endtask

  task automatic t_mode2();
    fresh(1'b0, 2'b01);
    max_conv1 = 4'd0;
    pulse_trig(2'b01); wait_quiet();
    check("R9 no irq first eos", int'(irq[0]), 0);
    pulse_trig(2'b01); wait_quiet();
    check("R9 irq second eos", int'(irq[0]), 1);
    pulse_clr(2'b01);
    pulse_trig(2'b01); wait_quiet();
    pulse_rst(2'b01);
    pulse_trig(2'b01); wait_quiet();
    check("R9 reset restarts count", int'(irq[0]), 0);
    pulse_trig(2'b01); wait_quiet();
    check("R9 irq after two", int'(irq[0]), 1);
  endtask

  task automatic t_casc();
    fresh(1'b1, 2'b00);
    max_conv1 = 4'd11;
    max_conv2 = 4'd3;
    pulse_trig(2'b01);
    pulse_trig(2'b10);
    wait_quiet();
    check("R6 16-slot N=11 writes", nlog, 12);
    check("R6 passes slot 8", lg[11], 11);
    check("R6 seq2 stays idle", busy1_seen, 0);
    max_conv1 = 4'd5;
    pulse_trig(2'b01);
    wait_quiet();
    check("R6 reaches 15", lg[15], 15);
    check("R6 wraps to 0", lg[16], 0);
  endtask

  task automatic t_mask();
    fresh(1'b0, 2'b00);
    max_conv1 = 4'hA;
    pulse_trig(2'b01);
    wait_quiet();
    check("R7 low bits only", nlog, 3);
  endtask

  task automatic t_share();
    fresh(1'b0, 2'b00);
    max_conv1 = 4'd1;
    max_conv2 = 4'd1;
    pulse_trig(2'b11);
    wait_quiet();
    check("R10 writes", nlog, 4);
    check("R10 seq1 first", lg[0], 0);
    check("R10 seq1 keeps priority", lg[1], 1);
    check("R10 seq2 after", lg[2], 8);
    check("R10 seq2 last", lg[3], 9);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cascade = 1'b0; trig = 2'b00; seq_rst = 2'b00;
    irq_mode = 2'b00; irq_clr = 2'b00; max_conv1 = 4'd0; max_conv2 = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_resume();
    t_pend();
    t_abort();
    t_seq2();
    t_mode2();
    t_casc();
    t_mask();
    t_share();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule